// File: doc/BRIEF.md
# Masked Address Range Event Detector

This block watches memory cycles on a processor bus and raises an event when a qualifying cycle falls inside a programmable address window. Two registers define the window. The base register holds the word address to compare against. The mask register holds a per-bit "don't care" mask, a read-cycle enable and a write-cycle enable. Both registers are reached through a simple indexed read/write port.

Each address bit in the compare range must equal the base bit where the mask bit is clear. Where the mask bit is set, that address bit always matches. A bus cycle produces a hit only if three conditions hold: the bus strobe is valid, the cycle type (read or write) has its enable set, and every compared bit matches.

A hit sets a sticky event flag. The flag appears as bit 1 of an 8-bit status word for a downstream packet serializer. The flag stays set until the serializer sends a one-cycle clear pulse after it has captured the packet.

Top module: `addr_window_watch`

## Requirements
- R1: After a synchronous active-low reset, both registers read as zero and the status word is zero. With both enables at zero, no bus cycle sets the event flag.
- R2: Register index 0 is the base register. A read returns the stored base field in bits CMP_HI:CMP_LO and zero in every other bit. Writes to the other bits are ignored.
- R3: Register index 1 is the mask register. It holds the mask field in bits CMP_HI:CMP_LO, the write-cycle enable in bit 1 and the read-cycle enable in bit 0. All other bits read as zero and ignore writes.
- R4: Writes to register indices 2 and 3 change neither register, and reads of those indices return zero.
- R5: For each address bit in CMP_HI:CMP_LO, a mask bit of 0 requires that address bit to equal the base bit. A mask bit of 1 makes that address bit always match.
- R6: Address bits above CMP_HI and below CMP_LO have no effect on the compare.
- R7: A read cycle can hit only when the read enable is 1, and a write cycle only when the write enable is 1. A cycle with both read and write indications hits if either of its enabled types matches.
- R8: A cycle is examined only when bus_valid is high together with bus_rd or bus_wr. Otherwise no hit occurs.
- R9: A hit in the cycle before a rising clock edge sets status_word bit 1 after that edge. All other status bits are always zero.
- R10: The event flag stays set through any number of later cycles, with or without hits, until pkt_clr is high at a clock edge. After that edge it reads zero.
- R11: If a hit and pkt_clr occur at the same edge, the event flag is set after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register index (0 base, 1 mask) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_sel (combinational) |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_rd | input | 1 | Memory read indication |
| bus_wr | input | 1 | Memory write indication |
| bus_addr | input | DATA_W | Bus cycle address |
| pkt_clr | input | 1 | One-cycle clear from the packet serializer |
| status_word | output | 8 | Outgoing status word; bit 1 is the event flag |

## Verification
The bench builds the block with DATA_W = 8, CMP_HI = 5 and CMP_LO = 2, so the compare field shrinks to four bits with two reserved bits above it and two enable bits below it. At that size it is practical to sweep every combination of base, mask, enable pair, compared address value and cycle type (read, write, both). Each expected hit is computed from the masked-equality rule. Random values in the ignored address bits and ones written into reserved register bits check the field boundaries at the same time.

// File: rtl/addr_window_pkg.sv
// Package: shared constants for the masked address window detector.
// Assumes a register port of four indices, two of which are decoded.
package addr_window_pkg;
    localparam int SEL_W      = 2;
    localparam logic [SEL_W-1:0] IDX_BASE = 2'd0;
    localparam logic [SEL_W-1:0] IDX_MASK = 2'd1;
    localparam int BIT_RD_EN  = 0;
    localparam int BIT_WR_EN  = 1;
    localparam int STATUS_W   = 8;
    localparam int EVENT_BIT  = 1;

    // Cycle-type view of a bus transfer.
    typedef struct packed {
        logic valid;
        logic rd;
        logic wr;
    } bus_cyc_t;
endpackage

// File: rtl/awin_regs.sv
// Module: awin_regs
// Holds the base and mask registers behind an indexed read/write port.
// Assumes: writes take effect at the clock edge; reads are combinational;
// reserved bits are neither stored nor returned.
module awin_regs
    import addr_window_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CMP_HI = 27,
    parameter int CMP_LO = 2,
    localparam int FLD_W = CMP_HI - CMP_LO + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [FLD_W-1:0]  base_fld,
    output logic [FLD_W-1:0]  mask_fld,
    output logic              rd_en,
    output logic              wr_en
);
    logic [FLD_W-1:0] base_q;
    logic [FLD_W-1:0] mask_q;
    logic             rd_en_q;
    logic             wr_en_q;
    logic             wr_base;
    logic             wr_mask;
    logic             unused_wdata_bits;

    assign wr_base = reg_wr && (reg_sel == IDX_BASE);
    assign wr_mask = reg_wr && (reg_sel == IDX_MASK);
    assign unused_wdata_bits = ^{reg_wdata[DATA_W-1:CMP_HI+1], reg_wdata[CMP_LO-1:BIT_WR_EN+1]};

    // Capture the base field on a base-index write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_base) begin
            base_q <= reg_wdata[CMP_HI:CMP_LO];
        end
    end

    // Capture the mask field and both cycle enables on a mask-index write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rd_en_q <= 1'b0;
            wr_en_q <= 1'b0;
        end else if (wr_mask) begin
            mask_q  <= reg_wdata[CMP_HI:CMP_LO];
            rd_en_q <= reg_wdata[BIT_RD_EN];
            wr_en_q <= reg_wdata[BIT_WR_EN];
        end
    end

    // Assemble read data for the selected index, reserved bits zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            IDX_BASE: reg_rdata[CMP_HI:CMP_LO] = base_q;
            IDX_MASK: begin
                reg_rdata[CMP_HI:CMP_LO] = mask_q;
                reg_rdata[BIT_WR_EN]     = wr_en_q;
                reg_rdata[BIT_RD_EN]     = rd_en_q;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign base_fld = base_q;
    assign mask_fld = mask_q;
    assign rd_en    = rd_en_q;
    assign wr_en    = wr_en_q;

    // R1: a reset cycle leaves both registers cleared.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (base_q == '0 && mask_q == '0 && !rd_en_q && !wr_en_q));

    // R4: writes to undecoded indices leave both registers untouched.
    assert_unmapped_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel != IDX_BASE && reg_sel != IDX_MASK) |=>
        ($stable(base_q) && $stable(mask_q) && $stable(rd_en_q) && $stable(wr_en_q)));
endmodule

// File: rtl/awin_match.sv
// Module: awin_match
// Masked equality compare of the address field against the base field,
// qualified by the bus strobe and per-type enables. Purely combinational.
// Assumes: only the compare slice of the address is presented here.
module awin_match
    import addr_window_pkg::*;
#(
    parameter int FLD_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] addr_fld,
    input  logic [FLD_W-1:0] base_fld,
    input  logic [FLD_W-1:0] mask_fld,
    input  logic             rd_en,
    input  logic             wr_en,
    input  bus_cyc_t         cyc,
    output logic             hit
);
    logic [FLD_W-1:0] bit_ok;
    logic             addr_match;
    logic             rd_take;
    logic             wr_take;

    // Per-bit compare: a set mask bit forces a match.
    for (genvar i = 0; i < FLD_W; i++) begin : g_bit
        assign bit_ok[i] = mask_fld[i] | ~(addr_fld[i] ^ base_fld[i]);
    end

    // Reduce bit results and qualify by cycle type.
    always_comb begin
        addr_match = &bit_ok;
        rd_take    = cyc.valid && cyc.rd && rd_en;
        wr_take    = cyc.valid && cyc.wr && wr_en;
        hit        = addr_match && (rd_take || wr_take);
    end

    // R8: no strobe, no hit.
    assert_no_hit_without_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc.valid |-> !hit);

    // R7: a disabled type alone never hits.
    assert_disabled_type_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_en || !cyc.rd) && (!wr_en || !cyc.wr)) |-> !hit);
endmodule

// File: rtl/awin_event.sv
// Module: awin_event
// Sticky event flag set by a hit and cleared by the serializer, and the
// status word that carries it at a fixed bit position.
// Assumes: pkt_clr is a single-cycle pulse; a hit wins over a clear.
module awin_event
    import addr_window_pkg::*;
#(
    parameter int SW = STATUS_W,
    parameter int EB = EVENT_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          pkt_clr,
    output logic [SW-1:0] status_word
);
    logic event_q;

    // Set on hit, drop on clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            event_q <= 1'b0;
        end else if (hit) begin
            event_q <= 1'b1;
        end else if (pkt_clr) begin
            event_q <= 1'b0;
        end
    end

    // Place the flag in its bit; every other bit stays zero.
    always_comb begin
        status_word     = '0;
        status_word[EB] = event_q;
    end

    // R9 / R11: any hit leaves the flag set after the edge.
    assert_hit_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> status_word[EB]);

    // R10: the flag holds without a clear.
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[EB] && !pkt_clr) |=> status_word[EB]);

    // R10: a clear without a hit drops the flag.
    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_clr && !hit) |=> !status_word[EB]);
endmodule

// File: rtl/addr_window_watch.sv
// Module: addr_window_watch (top)
// Flags bus memory cycles that fall in a masked address window and
// presents the sticky event as bit 1 of a status word.
// Assumes: synchronous active-low reset; address bits outside CMP_HI:CMP_LO
// are ignored; register reads are combinational.
module addr_window_watch
    import addr_window_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CMP_HI = 27,
    parameter int CMP_LO = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                bus_valid,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_addr,
    input  logic                pkt_clr,
    output logic [STATUS_W-1:0] status_word
);
    localparam int FLD_W = CMP_HI - CMP_LO + 1;

    logic [FLD_W-1:0] base_fld;
    logic [FLD_W-1:0] mask_fld;
    logic             rd_en;
    logic             wr_en;
    logic             hit;
    bus_cyc_t         cyc;
    logic             unused_addr_bits;

    assign cyc              = '{valid: bus_valid, rd: bus_rd, wr: bus_wr};
    assign unused_addr_bits = ^{bus_addr[DATA_W-1:CMP_HI+1], bus_addr[CMP_LO-1:0]};

    awin_regs #(.DATA_W(DATA_W), .CMP_HI(CMP_HI), .CMP_LO(CMP_LO)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .base_fld(base_fld), .mask_fld(mask_fld), .rd_en(rd_en), .wr_en(wr_en)
    );

    awin_match #(.FLD_W(FLD_W)) u_match (
        .clk(clk), .rst_n(rst_n), .addr_fld(bus_addr[CMP_HI:CMP_LO]),
        .base_fld(base_fld), .mask_fld(mask_fld), .rd_en(rd_en), .wr_en(wr_en),
        .cyc(cyc), .hit(hit)
    );

    awin_event #(.SW(STATUS_W), .EB(EVENT_BIT)) u_event (
        .clk(clk), .rst_n(rst_n), .hit(hit), .pkt_clr(pkt_clr),
        .status_word(status_word)
    );
endmodule

// File: tb/addr_window_watch_bench.sv
`timescale 1ns/1ps
module addr_window_watch_bench;
    localparam int DW = 8;
    localparam int HI = 5;
    localparam int LO = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          bus_valid = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_addr = '0;
    logic          pkt_clr = 1'b0;
    logic [7:0]    status_word;

    int  compared = 0;
    int  mismatched = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    addr_window_watch #(.DATA_W(DW), .CMP_HI(HI), .CMP_LO(LO)) u_addr_window_watch (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .pkt_clr(pkt_clr), .status_word(status_word)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [DW-1:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [DW-1:0] d);
        reg_sel = sel;
        #0.5;
        d = reg_rdata;
    endtask

    // One bus cycle, then the status is checked after the capturing edge.
    task automatic bus_cycle(input logic v, input logic r, input logic w, input logic [DW-1:0] a);
        bus_valid = v; bus_rd = r; bus_wr = w; bus_addr = a;
        tick();
        bus_valid = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic clear_pulse();
        pkt_clr = 1'b1;
        tick();
        pkt_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++; mismatched++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] rd;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state.
        chk("R1 status", status_word, 8'h00);
        reg_read(2'd0, rd); chk("R1 base", rd, 8'h00);
        reg_read(2'd1, rd); chk("R1 mask", rd, 8'h00);
        bus_cycle(1, 1, 0, 8'h00); chk("R1 rd no hit", status_word, 8'h00);
        bus_cycle(1, 0, 1, 8'h00); chk("R1 wr no hit", status_word, 8'h00);

        // R2/R3: reserved bits ignore ones.
        reg_write(2'd0, 8'hFF); reg_read(2'd0, rd); chk("R2 base rsvd", rd, 8'h3C);
        reg_write(2'd1, 8'hFF); reg_read(2'd1, rd); chk("R3 mask rsvd", rd, 8'h3F);
        reg_write(2'd1, 8'hC2); reg_read(2'd1, rd); chk("R3 wr en only", rd, 8'h02);

        // R4: undecoded indices.
        reg_write(2'd0, 8'h14); reg_write(2'd1, 8'h29);
        reg_write(2'd2, 8'hFF); reg_write(2'd3, 8'hEA);
        reg_read(2'd0, rd); chk("R4 base kept", rd, 8'h14);
        reg_read(2'd1, rd); chk("R4 mask kept", rd, 8'h29);
        reg_read(2'd2, rd); chk("R4 idx2 zero", rd, 8'h00);
        reg_read(2'd3, rd); chk("R4 idx3 zero", rd, 8'h00);

        // R8: strobe qualification; base 0, mask all ones, both enables.
        reg_write(2'd0, 8'h00); reg_write(2'd1, 8'h3F);
        bus_cycle(0, 1, 1, 8'h00); chk("R8 valid low", status_word, 8'h00);
        bus_cycle(1, 0, 0, 8'h00); chk("R8 no type", status_word, 8'h00);

        // R9/R10: set, hold across idle and misses, then clear.
        bus_cycle(1, 1, 0, 8'h00); chk("R9 set", status_word, 8'h02);
        reg_write(2'd1, 8'h00);
        bus_cycle(1, 1, 0, 8'hFC); chk("R10 hold miss", status_word, 8'h02);
        tick(); tick(); chk("R10 hold idle", status_word, 8'h02);
        clear_pulse(); chk("R10 clear", status_word, 8'h00);

        // R11: hit coincident with clear.
        reg_write(2'd1, 8'h01);
        bus_cycle(1, 1, 0, 8'h00); chk("R11 pre", status_word, 8'h02);
        pkt_clr = 1'b1;
        bus_cycle(1, 1, 0, 8'h03);
        pkt_clr = 1'b0;
        chk("R11 coincident", status_word, 8'h02);
        clear_pulse(); chk("R11 cleared", status_word, 8'h00);

        // R5/R6/R7/R9: exhaustive sweep over the small configuration.
        for (int b = 0; b < 16; b++) begin
            for (int m = 0; m < 16; m++) begin
                for (int ev = 0; ev < 4; ev++) begin
                    reg_write(2'd0, {2'b11, b[3:0], 2'b11});
                    reg_write(2'd1, {2'b11, m[3:0], ev[1:0]});
                    for (int a = 0; a < 16; a++) begin
                        for (int t = 0; t < 3; t++) begin
                            logic match;
                            logic exp_hit;
                            logic [1:0] up;
                            logic [1:0] lo;
                            up = 2'($urandom);
                            lo = 2'($urandom);
                            match   = (((a[3:0] ^ b[3:0]) & ~m[3:0]) == 4'h0);
                            exp_hit = match && ((t != 1 && ev[0]) || (t != 0 && ev[1]));
                            bus_cycle(1'b1, t != 1, t != 0, {up, a[3:0], lo});
                            chk("R5 R6 R7 R9 sweep", status_word, {6'b0, exp_hit, 1'b0});
                            if (exp_hit) clear_pulse();
                        end
                    end
                end
            end
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule